// File: doc/BRIEF.md
# SAR Converter Serial Readout Controller

This block sits on the host side of an 18-bit successive-approximation converter. The converter is wired in chip-select mode with a busy indicator. When a start request arrives, the controller raises the convert strobe while the select line is still high. It then pulls the select line low so that the converter can report completion. While the conversion runs, the converter's data line floats and a pull-up holds it high. The converter signals end of conversion by driving that line low. The controller treats this falling level as an interrupt and only then starts the serial clock. It collects 18 bits, most significant first, and presents the word with a one-cycle valid pulse.

The convert strobe stays high through both the conversion and the readback. When the last bit has been captured, the select line goes high again, which floats the converter's output, and the strobe falls. If the end-of-conversion level never appears within a programmable number of cycles, the controller aborts and pulses an error output. In both cases a programmable minimum cycle time, measured from one strobe rise, must pass before the next start is accepted.

The controller is built around seven named states:
- IDLE: waiting for start.
- ARM: the strobe rises while select is high.
- CONV: select is low and the controller waits for the busy-low level or a timeout.
- READ: the serial clock runs.
- DONE: the valid pulse.
- FAIL: the error pulse.
- HOLD: waiting out the minimum cycle time.

Transitions:
- IDLE→ARM on start.
- ARM→CONV unconditionally.
- CONV→READ on busy-low.
- CONV→FAIL on timeout.
- READ→DONE after the 18th bit.
- DONE→HOLD and FAIL→HOLD unconditionally.
- HOLD→IDLE once the cycle time has elapsed.

Top module: `sar_rd_ctrl`

## Requirements
- R1: After reset the strobe `cnv_o` is low, the select line `sdi_o` is high, `sck_o` is low, `valid_o` and `err_o` are low, and `ready_o` is high.
- R2: A start request accepted while `ready_o` is high raises `cnv_o` in a cycle in which `sdi_o` is high.
- R3: `sdi_o` goes low one cycle after `cnv_o` rises. It stays low until the readback or the abort ends, and then returns high.
- R4: Every falling edge of `sck_o` occurs while `cnv_o` is high and `sdi_o` is low.
- R5: `sck_o` remains low until the synchronised data line has been seen low during the conversion wait.
- R6: Each successful conversion produces exactly 18 falling edges of `sck_o`. The bit present on `sdo_i` after the k-th falling edge is result bit 18-k, so bit 17 comes first.
- R7: `valid_o` is a single-cycle pulse with the captured word on `result_o`. `result_o` keeps that value until the next successful conversion.
- R8: If the data line is not seen low within `tmo_i` cycles of waiting, `err_o` pulses for one cycle exactly `tmo_i`+2 cycles after `cnv_o` rises. At the same time `cnv_o` falls and `sdi_o` rises, no valid pulse follows, and `result_o` is unchanged.
- R9: Two rises of `cnv_o` are at least `cyc_i`+1 cycles apart. A start request while `ready_o` is low is dropped.
- R10: Each high phase and each low phase of `sck_o` lasts `div_i`+1 clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Conversion request, taken only while ready |
| div_i | input | DIV_W (4) | Serial clock half-period minus one, in clock cycles |
| tmo_i | input | TMO_W (12) | Maximum busy wait in cycles before abort |
| cyc_i | input | CYC_W (12) | Minimum cycles between strobe rises |
| sdo_i | input | 1 | Converter serial data / busy line (pulled up when floating) |
| cnv_o | output | 1 | Convert strobe |
| sdi_o | output | 1 | Select line to the converter |
| sck_o | output | 1 | Serial clock |
| ready_o | output | 1 | High in IDLE; start accepted |
| result_o | output | DATA_W (18) | Last captured result word |
| valid_o | output | 1 | One-cycle pulse when a new word is on result_o |
| err_o | output | 1 | One-cycle pulse on conversion timeout |

## Verification
Some properties are checked on every clock by assertions:
- the strobe rises only with select high;
- select drops in the cycle after the strobe rises;
- clock edges happen only inside the strobe-high, select-low window;
- no clock runs while the controller waits for busy;
- the valid pulse lasts one cycle;
- an error follows only a conversion wait;
- successive strobe rises respect the minimum cycle time.

Other behaviour only the bench scenarios can show, through a converter model that shifts real words out on clock falls:
- that the word assembled is the one the converter sent;
- the bit order;
- the exact count of clock falls;
- the clock period for several divider settings;
- the exact abort cycle;
- the result held unchanged through an abort;
- a start dropped during the hold-off.

// File: rtl/sar_rd_pkg.sv
package sar_rd_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ARM,
        S_CONV,
        S_READ,
        S_DONE,
        S_FAIL,
        S_HOLD
    } rd_state_e;

endpackage

// File: rtl/sar_rd_cnt.sv
module sar_rd_cnt #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         en_i,
    output logic [W-1:0] cnt_o
);

    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (clr_i) begin
            cnt_o <= '0;
        end else if (en_i && (cnt_o != CNT_MAX)) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end

endmodule

// File: rtl/sar_rd_sync.sv
module sar_rd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] pipe_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q <= '1;
                else        pipe_q <= d_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q <= '1;
                else        pipe_q <= {pipe_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/sar_rd_sck_gen.sv
module sar_rd_sck_gen #(
    parameter int NBITS = 18,
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             sck_o,
    output logic             samp_o,
    output logic             last_o
);

    localparam int CW = $clog2(NBITS + 1);
    localparam logic [CW-1:0] FALLS_END = CW'(NBITS);

    logic [DIV_W-1:0] half_q;
    logic [CW-1:0]    falls_q;
    logic             sck_q;
    logic             half_end;

    assign half_end = (half_q == div_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q  <= '0;
            falls_q <= '0;
            sck_q   <= 1'b0;
        end else if (!run_i) begin
            half_q  <= '0;
            falls_q <= '0;
            sck_q   <= 1'b0;
        end else if (half_end) begin
            half_q <= '0;
            if (sck_q) begin
                sck_q   <= 1'b0;
                falls_q <= falls_q + 1'b1;
            end else if (falls_q != FALLS_END) begin
                sck_q <= 1'b1;
            end
        end else begin
            half_q <= half_q + 1'b1;
        end
    end

    assign sck_o  = sck_q;
    assign samp_o = run_i && half_end && !sck_q && (falls_q != '0);
    assign last_o = samp_o && (falls_q == FALLS_END);

    AST_FALL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        falls_q <= FALLS_END); // R6

endmodule

// File: rtl/sar_rd_shift.sv
module sar_rd_shift #(
    parameter int N = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_i,
    input  logic         load_i,
    input  logic         bit_i,
    output logic [N-1:0] word_o
);

    logic [N-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            word_o <= '0;
        end else begin
            if (shift_i) sh_q   <= {sh_q[N-2:0], bit_i};
            if (load_i)  word_o <= {sh_q[N-2:0], bit_i};
        end
    end

endmodule

// File: rtl/sar_rd_ctrl.sv
module sar_rd_ctrl
    import sar_rd_pkg::*;
#(
    parameter int DATA_W      = 18,
    parameter int DIV_W       = 4,
    parameter int TMO_W       = 12,
    parameter int CYC_W       = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic [TMO_W-1:0]  tmo_i,
    input  logic [CYC_W-1:0]  cyc_i,
    input  logic              sdo_i,
    output logic              cnv_o,
    output logic              sdi_o,
    output logic              sck_o,
    output logic              ready_o,
    output logic [DATA_W-1:0] result_o,
    output logic              valid_o,
    output logic              err_o
);

    localparam logic [TMO_W-1:0] BLANK = TMO_W'(SYNC_STAGES);

    rd_state_e        state_q, state_d;
    logic [CYC_W-1:0] cyc_cnt;
    logic [TMO_W-1:0] conv_cnt;
    logic             sdo_sync;
    logic             eoc, tmo_hit;
    logic             samp, last_bit;

    // -------- support blocks --------
    sar_rd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(sdo_i), .q_o(sdo_sync)
    );

    sar_rd_cnt #(.W(CYC_W)) u_cyc_cnt (
        .clk(clk), .rst_n(rst_n),
        .clr_i(state_q == S_IDLE && start_i), .en_i(1'b1), .cnt_o(cyc_cnt)
    );

    sar_rd_cnt #(.W(TMO_W)) u_conv_cnt (
        .clk(clk), .rst_n(rst_n),
        .clr_i(state_q != S_CONV), .en_i(1'b1), .cnt_o(conv_cnt)
    );

    sar_rd_sck_gen #(.NBITS(DATA_W), .DIV_W(DIV_W)) u_sck (
        .clk(clk), .rst_n(rst_n), .run_i(state_q == S_READ), .div_i(div_i),
        .sck_o(sck_o), .samp_o(samp), .last_o(last_bit)
    );

    sar_rd_shift #(.N(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .shift_i(samp), .load_i(last_bit),
        .bit_i(sdo_i), .word_o(result_o)
    );

    assign eoc     = (state_q == S_CONV) && !sdo_sync && (conv_cnt >= BLANK);
    assign tmo_hit = (state_q == S_CONV) && (conv_cnt >= tmo_i);

    // -------- state register --------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // -------- next state --------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start_i)  state_d = S_ARM;
            S_ARM:                state_d = S_CONV;
            S_CONV: begin
                if (eoc)          state_d = S_READ;
                else if (tmo_hit) state_d = S_FAIL;
            end
            S_READ: if (last_bit) state_d = S_DONE;
            S_DONE:               state_d = S_HOLD;
            S_FAIL:               state_d = S_HOLD;
            S_HOLD: if (cyc_cnt >= cyc_i) state_d = S_IDLE;
            default:              state_d = S_IDLE;
        endcase
    end

    // -------- outputs --------
    always_comb begin
        cnv_o   = 1'b0;
        sdi_o   = 1'b1;
        ready_o = 1'b0;
        valid_o = 1'b0;
        err_o   = 1'b0;
        unique case (state_q)
            S_IDLE: ready_o = 1'b1;
            S_ARM:  cnv_o   = 1'b1;
            S_CONV: begin cnv_o = 1'b1; sdi_o = 1'b0; end
            S_READ: begin cnv_o = 1'b1; sdi_o = 1'b0; end
            S_DONE: valid_o = 1'b1;
            S_FAIL: err_o   = 1'b1;
            S_HOLD: ;
            default: ;
        endcase
    end

    // -------- checks --------
    logic             cnv_q, seen_q;
    logic [CYC_W-1:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnv_q  <= 1'b0;
            seen_q <= 1'b0;
            gap_q  <= '0;
        end else begin
            cnv_q <= cnv_o;
            if (cnv_o && !cnv_q) begin
                seen_q <= 1'b1;
                gap_q  <= '0;
            end else if (gap_q != {CYC_W{1'b1}}) begin
                gap_q <= gap_q + 1'b1;
            end
        end
    end

    AST_ARM_SEL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (cnv_o && !cnv_q) |-> sdi_o); // R2
    AST_SEL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (cnv_o && !cnv_q) |=> !sdi_o); // R3
    AST_SCK_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sck_o) |-> (cnv_o && !sdi_o)); // R4
    AST_NO_SCK_IN_CONV: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CONV) |-> !sck_o); // R5
    AST_VALID_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o); // R7
    AST_ERR_AFTER_CONV: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> ($past(state_q) == S_CONV)); // R8
    AST_MIN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnv_o && !cnv_q && seen_q) |-> (gap_q >= cyc_i)); // R9

endmodule

// File: tb/sar_rd_ctrl_bench.sv
module sar_rd_ctrl_bench;

    localparam int TMO = 60;
    localparam int CYC = 120;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [3:0]  div_i = 4'd1;
    logic [11:0] tmo_i = 12'(TMO);
    logic [11:0] cyc_i = 12'(CYC);
    logic        sdo_m = 1'b1;
    logic        cnv_o, sdi_o, sck_o, ready_o, valid_o, err_o;
    logic [17:0] result_o;

    always #2 clk = ~clk;

    sar_rd_ctrl u_sar_rd_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .div_i(div_i),
        .tmo_i(tmo_i), .cyc_i(cyc_i), .sdo_i(sdo_m), .cnv_o(cnv_o),
        .sdi_o(sdi_o), .sck_o(sck_o), .ready_o(ready_o),
        .result_o(result_o), .valid_o(valid_o), .err_o(err_o)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    typedef struct packed {
        logic        is_err;
        logic [17:0] word;
    } exp_t;

    exp_t exp_q[$];
    int   pushed = 0;
    int   got = 0;

    // converter model
    logic [17:0] m_word = '0;
    int  m_delay = 10;
    bit  m_eoc_en = 1'b1;
    int  m_state = 0;
    int  m_cnt = 0;
    int  m_falls = 0;
    int  fall_gap = 0;
    int  since_rise = 0;
    int  cnv_rises = 0;
    bit  sel_seen = 1'b0;
    logic p_cnv = 1'b0, p_sck = 1'b0, p_sdi = 1'b1;

    always @(negedge clk) begin
        if (!rst_n) begin
            sdo_m = 1'b1; m_state = 0; p_cnv = 1'b0; p_sck = 1'b0; p_sdi = 1'b1;
        end else begin
            since_rise++;
            fall_gap++;
            if (cnv_o && !p_cnv) begin
                cnv_rises++;
                check(sdi_o == 1'b1, "R2 select high at strobe rise", sdi_o, 1);
                if (cnv_rises > 1)
                    check(since_rise >= CYC + 1, "R9 strobe rise spacing", since_rise, CYC + 1);
                since_rise = 0;
                m_state = 1; m_cnt = 0; m_falls = 0; sel_seen = 1'b0;
                sdo_m = 1'b1;
            end else if (m_state == 1) begin
                m_cnt++;
                if (!sdi_o && !sel_seen) begin
                    sel_seen = 1'b1;
                    check(m_cnt == 1, "R3 select low after strobe", m_cnt, 1);
                end
                if (err_o)
                    check(m_cnt == TMO + 2, "R8 abort cycle", m_cnt, TMO + 2);
                if (m_eoc_en && m_cnt == m_delay) begin
                    sdo_m = 1'b0;
                    m_state = 2;
                end
            end
            if (p_sck && !sck_o) begin
                m_falls++;
                check(cnv_o && !sdi_o, "R4 clock fall window", {cnv_o, sdi_o}, 2'b10);
                check(m_state == 2, "R5 clock only after busy low", m_state, 2);
                if (m_falls == 2)
                    check(fall_gap == 2 * (int'(div_i) + 1), "R10 clock period",
                          fall_gap, 2 * (int'(div_i) + 1));
                fall_gap = 0;
                if (m_falls <= 18) sdo_m = m_word[18 - m_falls];
                else               sdo_m = 1'b1;
            end
            if (sdi_o && !p_sdi) begin
                check(!cnv_o, "R3 strobe low when select returns", cnv_o, 0);
                if (m_state == 2)
                    check(m_falls == 18, "R6 clock fall count", m_falls, 18);
                sdo_m = 1'b1;
                m_state = 0;
            end
            p_cnv = cnv_o; p_sck = sck_o; p_sdi = sdi_o;
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && (valid_o || err_o)) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected completion", {valid_o, err_o}, 0);
            end else begin
                exp_t it;
                it = exp_q.pop_front();
                if (it.is_err)
                    check(err_o && !valid_o, "R8 abort reported", {err_o, valid_o}, 2'b10);
                else
                    check(valid_o && result_o == it.word, "R6 R7 result word", result_o, it.word);
                got++;
            end
        end
    end

    task automatic run_conv(input logic [17:0] w, input int dly, input bit eoc, input logic [3:0] dv);
        exp_t it;
        while (!ready_o) @(negedge clk);
        div_i = dv; m_word = w; m_delay = dly; m_eoc_en = eoc;
        it.is_err = !eoc; it.word = w;
        exp_q.push_back(it);
        pushed++;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (got < pushed) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!cnv_o && sdi_o && !sck_o, "R1 reset pins", {cnv_o, sdi_o, sck_o}, 3'b010);
        check(!valid_o && !err_o && ready_o, "R1 reset flags", {valid_o, err_o, ready_o}, 3'b001);

        run_conv(18'h2A5C3, 20, 1'b1, 4'd1);
        run_conv(18'h3FFFF, 5, 1'b1, 4'd0);
        run_conv(18'h00000, 40, 1'b1, 4'd3);
        run_conv(18'h20001, 12, 1'b1, 4'd7);
        repeat (5) @(negedge clk);
        check(result_o == 18'h20001, "R7 result held", result_o, 18'h20001);

        run_conv(18'h15555, 0, 1'b0, 4'd1);
        repeat (3) @(negedge clk);
        check(result_o == 18'h20001, "R8 result unchanged by abort", result_o, 18'h20001);

        run_conv(18'h0F0F0, 8, 1'b1, 4'd2);
        begin
            int rises_before;
            rises_before = cnv_rises;
            check(!ready_o, "R9 not ready in hold-off", ready_o, 0);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            repeat (30) @(negedge clk);
            check(cnv_rises == rises_before, "R9 start dropped", cnv_rises, rises_before);
            check(!cnv_o, "R9 strobe idle", cnv_o, 0);
        end
        run_conv(18'h1A2B3, 15, 1'b1, 4'd1);
        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R7 scoreboard drained", exp_q.size(), 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", got, pushed);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule